// File: doc/BRIEF.md
# Single-Cycle Control Decoder with Shift and Register-Jump Support

This block is the combinational control unit of a single-cycle load/store processor datapath. From the 6-bit primary opcode and the 6-bit function field of the current instruction it produces every select and enable the datapath needs: the destination-register select, the immediate operand select, the write-back source select, the register-file write enable, the data-memory read and write enables, the conditional-branch and absolute-jump enables, the 2-bit ALU class code and the 4-bit ALU operation.

Two instructions share the register-register opcode but need datapath steering that the other register-register operations do not. The logical right shift needs the instruction's 5-bit shift-amount field routed into the ALU, which this block requests with a shift-amount select. The register jump needs the next PC taken from the first source register, which this block requests with a PC-from-register select. Both are found by inspecting the function field. The control words of every instruction the decoder already handled stay the same.

Unknown opcodes and unknown function codes under the register-register opcode decode to a word with every write, memory, branch and jump enable low, so they cannot change any architectural state.

Top module: `ctl_decode_top`

## Requirements
- R1: For opcode 000000 with funct 100000 (add), 100010 (sub), 100100 (and), 100101 (or), 100111 (nor) or 101010 (slt): o_dst_rd=1, o_reg_wr=1, o_alu_op=2'b10, every other enable and select 0.
- R2: With o_alu_op=2'b10 the ALU operation is add=4'b0010, sub=4'b0110, and=4'b0000, or=4'b0001, slt=4'b0111, nor=4'b1100.
- R3: For opcode 000000 with funct 000010 (logical right shift): o_alu_op=2'b11, o_alu_fn=4'b1000, o_dst_rd=1, o_reg_wr=1, o_shamt_sel=1, all other enables and selects 0.
- R4: o_shamt_sel is 1 for the logical right shift and 0 for every other opcode/funct pair.
- R5: For opcode 000000 with funct 001000 (register jump): o_pc_from_reg=1 and every other output bit 0 except o_alu_fn=4'b0010; o_pc_from_reg is 0 for every other pair.
- R6: Opcode 100011 (load): o_alu_src_imm=1, o_wb_from_mem=1, o_reg_wr=1, o_mem_rd=1, o_alu_op=2'b00, others 0.
- R7: Opcode 101011 (store): o_alu_src_imm=1, o_mem_wr=1, o_alu_op=2'b00, others 0.
- R8: Opcode 000100 (branch if equal): o_branch=1, o_alu_op=2'b01, o_alu_fn=4'b0110, others 0.
- R9: Opcode 000010 (jump): o_jump=1, o_alu_op=2'b00, others 0.
- R10: Any other opcode drives every output bit 0 except o_alu_fn=4'b0010.
- R11: Opcode 000000 with an unlisted funct drives every output bit 0 except o_alu_fn=4'b0010.
- R12: o_alu_op=2'b00 gives o_alu_fn=4'b0010 and o_alu_op=2'b01 gives o_alu_fn=4'b0110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_opcode | input | 6 | Primary opcode field of the instruction |
| i_funct | input | 6 | Function field of the instruction |
| o_dst_rd | output | 1 | Write register is rd (1) or rt (0) |
| o_alu_src_imm | output | 1 | Second ALU operand is the sign-extended immediate |
| o_wb_from_mem | output | 1 | Write-back data comes from data memory |
| o_reg_wr | output | 1 | Register-file write enable |
| o_mem_rd | output | 1 | Data-memory read enable |
| o_mem_wr | output | 1 | Data-memory write enable |
| o_branch | output | 1 | Conditional branch on ALU zero |
| o_jump | output | 1 | Absolute jump target select |
| o_alu_op | output | 2 | ALU class code |
| o_alu_fn | output | 4 | Decoded ALU operation |
| o_shamt_sel | output | 1 | Shift-amount field drives the ALU shift input |
| o_pc_from_reg | output | 1 | Next PC comes from the rs register value |

## Verification
The assertions watch, whenever the inputs settle, that memory read and write are never both enabled, that the shift-amount select only appears with the shift ALU class, that a register jump never writes a register or memory, that an unknown opcode leaves every enable low, and that the shift class always yields the shift operation code. The exact control word for each instruction, the ALU operation codes for each function value and the silence of unlisted function codes are shown only by the bench, which compares every output bit against a word computed from the requirements for each directed and random opcode/funct pair.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W    = 6;
  localparam int FN_W    = 6;
  localparam int ALUFN_W = 4;
  localparam int CLS_W   = 2;

  localparam logic [OP_W-1:0] OPC_RRR  = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STOR = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BREQ = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JABS = 6'b000010;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_NOR = 6'b100111;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;
  localparam logic [FN_W-1:0] FN_SHR = 6'b000010;
  localparam logic [FN_W-1:0] FN_JRG = 6'b001000;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADD = 2'b00,
    CLS_SUB = 2'b01,
    CLS_FN  = 2'b10,
    CLS_SHR = 2'b11
  } alu_cls_e;

  localparam logic [ALUFN_W-1:0] AF_AND = 4'b0000;
  localparam logic [ALUFN_W-1:0] AF_OR  = 4'b0001;
  localparam logic [ALUFN_W-1:0] AF_ADD = 4'b0010;
  localparam logic [ALUFN_W-1:0] AF_SUB = 4'b0110;
  localparam logic [ALUFN_W-1:0] AF_SLT = 4'b0111;
  localparam logic [ALUFN_W-1:0] AF_NOR = 4'b1100;
  localparam logic [ALUFN_W-1:0] AF_SHR = 4'b1000;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     wb_mem;
    logic     reg_wr;
    logic     mem_rd;
    logic     mem_wr;
    logic     branch;
    logic     jump;
    alu_cls_e cls;
    logic     shamt_sel;
    logic     pc_reg;
  } ctl_word_t;
endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int FNW = FN_W
) (
  input  logic [OPW-1:0] i_opcode,
  input  logic [FNW-1:0] i_funct,
  output ctl_word_t      o_ctl
);
  logic fn_arith;

  always_comb begin
    unique case (i_funct)
      FN_ADD, FN_SUB, FN_AND, FN_OR, FN_NOR, FN_SLT: fn_arith = 1'b1;
      default:                                       fn_arith = 1'b0;
    endcase
  end

  always_comb begin
    o_ctl     = '0;
    o_ctl.cls = CLS_ADD;
    case (i_opcode)
      OPC_RRR: begin
        if (fn_arith) begin
          o_ctl.dst_rd = 1'b1;
          o_ctl.reg_wr = 1'b1;
          o_ctl.cls    = CLS_FN;
        end else if (i_funct == FN_SHR) begin
          o_ctl.dst_rd    = 1'b1;
          o_ctl.reg_wr    = 1'b1;
          o_ctl.cls       = CLS_SHR;
          o_ctl.shamt_sel = 1'b1;
        end else if (i_funct == FN_JRG) begin
          o_ctl.pc_reg = 1'b1;
        end
      end
      OPC_LOAD: begin
        o_ctl.src_imm = 1'b1;
        o_ctl.wb_mem  = 1'b1;
        o_ctl.reg_wr  = 1'b1;
        o_ctl.mem_rd  = 1'b1;
      end
      OPC_STOR: begin
        o_ctl.src_imm = 1'b1;
        o_ctl.mem_wr  = 1'b1;
      end
      OPC_BREQ: begin
        o_ctl.branch = 1'b1;
        o_ctl.cls    = CLS_SUB;
      end
      OPC_JABS: o_ctl.jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    assert_mem_excl_R6: assert (!(o_ctl.mem_rd && o_ctl.mem_wr))
      else $error("memory read and write both enabled");
    assert_shamt_cls_R4: assert (!o_ctl.shamt_sel || o_ctl.cls == CLS_SHR)
      else $error("shift-amount select without shift class");
    assert_jr_quiet_R5: assert (!o_ctl.pc_reg ||
                                !(o_ctl.reg_wr || o_ctl.mem_wr || o_ctl.branch || o_ctl.jump))
      else $error("register jump with side effect");
    assert_unknown_quiet_R10: assert (
        (i_opcode inside {OPC_RRR, OPC_LOAD, OPC_STOR, OPC_BREQ, OPC_JABS}) ||
        !(o_ctl.reg_wr || o_ctl.mem_rd || o_ctl.mem_wr || o_ctl.branch || o_ctl.jump ||
          o_ctl.pc_reg))
      else $error("unknown opcode enabled a side effect");
  end
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
  import ctl_pkg::*;
#(
  parameter int FNW = FN_W,
  parameter int AFW = ALUFN_W
) (
  input  alu_cls_e       i_cls,
  input  logic [FNW-1:0] i_funct,
  output logic [AFW-1:0] o_fn
);
  always_comb begin
    unique case (i_cls)
      CLS_ADD: o_fn = AF_ADD;
      CLS_SUB: o_fn = AF_SUB;
      CLS_SHR: o_fn = AF_SHR;
      CLS_FN: begin
        case (i_funct)
          FN_ADD:  o_fn = AF_ADD;
          FN_SUB:  o_fn = AF_SUB;
          FN_AND:  o_fn = AF_AND;
          FN_OR:   o_fn = AF_OR;
          FN_NOR:  o_fn = AF_NOR;
          FN_SLT:  o_fn = AF_SLT;
          default: o_fn = AF_ADD;
        endcase
      end
      default: o_fn = AF_ADD;
    endcase
  end

  always_comb begin
    assert_shr_code_R3: assert (i_cls != CLS_SHR || o_fn == AF_SHR)
      else $error("shift class did not give shift operation");
  end
endmodule

// File: rtl/ctl_decode_top.sv
module ctl_decode_top
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0]    i_opcode,
  input  logic [FN_W-1:0]    i_funct,
  output logic               o_dst_rd,
  output logic               o_alu_src_imm,
  output logic               o_wb_from_mem,
  output logic               o_reg_wr,
  output logic               o_mem_rd,
  output logic               o_mem_wr,
  output logic               o_branch,
  output logic               o_jump,
  output logic [CLS_W-1:0]   o_alu_op,
  output logic [ALUFN_W-1:0] o_alu_fn,
  output logic               o_shamt_sel,
  output logic               o_pc_from_reg
);
  ctl_word_t ctl;

  ctl_main_dec #(.OPW(OP_W), .FNW(FN_W)) i_main (
    .i_opcode (i_opcode),
    .i_funct  (i_funct),
    .o_ctl    (ctl)
  );

  ctl_alu_dec #(.FNW(FN_W), .AFW(ALUFN_W)) i_alu (
    .i_cls   (ctl.cls),
    .i_funct (i_funct),
    .o_fn    (o_alu_fn)
  );

  assign o_dst_rd      = ctl.dst_rd;
  assign o_alu_src_imm = ctl.src_imm;
  assign o_wb_from_mem = ctl.wb_mem;
  assign o_reg_wr      = ctl.reg_wr;
  assign o_mem_rd      = ctl.mem_rd;
  assign o_mem_wr      = ctl.mem_wr;
  assign o_branch      = ctl.branch;
  assign o_jump        = ctl.jump;
  assign o_alu_op      = ctl.cls;
  assign o_shamt_sel   = ctl.shamt_sel;
  assign o_pc_from_reg = ctl.pc_reg;
endmodule

// File: tb/test_ctl_decode_top.sv
module test_ctl_decode_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic [5:0] funct = 6'd0;
  logic       dst_rd, src_imm, wb_mem, reg_wr, mem_rd, mem_wr, branch, jump;
  logic [1:0] alu_op;
  logic [3:0] alu_fn;
  logic       shamt_sel, pc_reg;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_decode_top i_ctl_decode_top (
    .i_opcode      (opcode),
    .i_funct       (funct),
    .o_dst_rd      (dst_rd),
    .o_alu_src_imm (src_imm),
    .o_wb_from_mem (wb_mem),
    .o_reg_wr      (reg_wr),
    .o_mem_rd      (mem_rd),
    .o_mem_wr      (mem_wr),
    .o_branch      (branch),
    .o_jump        (jump),
    .o_alu_op      (alu_op),
    .o_alu_fn      (alu_fn),
    .o_shamt_sel   (shamt_sel),
    .o_pc_from_reg (pc_reg)
  );

  // word layout: dst,imm,wbm,rw,mr,mw,br,jmp,op[1:0],fn[3:0],shamt,pcreg
  function automatic logic [15:0] pack(input logic d, i, w, r, mr, mw, b, j,
                                       input logic [1:0] op, input logic [3:0] fn,
                                       input logic s, p);
    return {d, i, w, r, mr, mw, b, j, op, fn, s, p};
  endfunction

  function automatic logic [15:0] expect_word(input logic [5:0] oc, input logic [5:0] fc,
                                              output string tag);
    logic [15:0] w;
    w = pack(0,0,0,0,0,0,0,0,2'b00,4'b0010,0,0);
    tag = "R10";
    if (oc == 6'b000000) begin
      tag = "R11";
      case (fc)
        6'b100000: begin w = pack(1,0,0,1,0,0,0,0,2'b10,4'b0010,0,0); tag = "R1/R2 add"; end
        6'b100010: begin w = pack(1,0,0,1,0,0,0,0,2'b10,4'b0110,0,0); tag = "R1/R2 sub"; end
        6'b100100: begin w = pack(1,0,0,1,0,0,0,0,2'b10,4'b0000,0,0); tag = "R1/R2 and"; end
        6'b100101: begin w = pack(1,0,0,1,0,0,0,0,2'b10,4'b0001,0,0); tag = "R1/R2 or"; end
        6'b100111: begin w = pack(1,0,0,1,0,0,0,0,2'b10,4'b1100,0,0); tag = "R1/R2 nor"; end
        6'b101010: begin w = pack(1,0,0,1,0,0,0,0,2'b10,4'b0111,0,0); tag = "R1/R2 slt"; end
        6'b000010: begin w = pack(1,0,0,1,0,0,0,0,2'b11,4'b1000,1,0); tag = "R3/R4 shr"; end
        6'b001000: begin w = pack(0,0,0,0,0,0,0,0,2'b00,4'b0010,0,1); tag = "R5 jr"; end
        default: ;
      endcase
    end else if (oc == 6'b100011) begin
      w = pack(0,1,1,1,1,0,0,0,2'b00,4'b0010,0,0); tag = "R6/R12 load";
    end else if (oc == 6'b101011) begin
      w = pack(0,1,0,0,0,1,0,0,2'b00,4'b0010,0,0); tag = "R7/R12 store";
    end else if (oc == 6'b000100) begin
      w = pack(0,0,0,0,0,0,1,0,2'b01,4'b0110,0,0); tag = "R8/R12 beq";
    end else if (oc == 6'b000010) begin
      w = pack(0,0,0,0,0,0,0,1,2'b00,4'b0010,0,0); tag = "R9 jump";
    end
    return w;
  endfunction

  task automatic apply_check(input logic [5:0] oc, input logic [5:0] fc);
    logic [15:0] exp_w, act_w;
    string tag;
    opcode = oc;
    funct  = fc;
    @(negedge clk);
    exp_w = expect_word(oc, fc, tag);
    act_w = pack(dst_rd, src_imm, wb_mem, reg_wr, mem_rd, mem_wr, branch, jump,
                 alu_op, alu_fn, shamt_sel, pc_reg);
    n_checks++;
    if (act_w !== exp_w) begin
      n_errors++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b", tag, oc, fc, act_w, exp_w);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0] known_op [5];
    logic [5:0] known_fn [8];
    int unused_seed;
    known_op = '{6'b000000, 6'b100011, 6'b101011, 6'b000100, 6'b000010};
    known_fn = '{6'b100000, 6'b100010, 6'b100100, 6'b100101,
                 6'b100111, 6'b101010, 6'b000010, 6'b001000};
    unused_seed = $urandom(32'h5eed_1234);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // first vector is the all-zero reset pattern: opcode 0 funct 0 (R11)
    apply_check(6'b000000, 6'b000000);
    // directed: every register-register function incl. shift (R3) and jr (R5)
    for (int k = 0; k < 8; k++) apply_check(6'b000000, known_fn[k]);
    // directed: memory, branch, jump with varied funct (funct must not matter)
    for (int k = 1; k < 5; k++) begin
      apply_check(known_op[k], 6'b000000);
      apply_check(known_op[k], 6'b000010);
      apply_check(known_op[k], 6'b001000);
    end
    // directed corners: unknown opcodes (R10), near-miss functs (R11)
    apply_check(6'b111111, 6'b000010);
    apply_check(6'b000011, 6'b001000);
    apply_check(6'b000000, 6'b000011);
    apply_check(6'b000000, 6'b001001);
    apply_check(6'b000000, 6'b100001);
    // exhaustive sweep of every pair under the register-register opcode
    for (int f = 0; f < 64; f++) apply_check(6'b000000, 6'(f));
    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      logic [5:0] oc, fc;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 5) oc = known_op[sel];
      else oc = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 3) != 0) fc = known_fn[$urandom_range(0, 7)];
      else fc = 6'($urandom_range(0, 63));
      apply_check(oc, fc);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule